// File: doc/BRIEF.md
# Adaptive Mesh Router Input Port

This block is one input port of a five-port router in a two-dimensional mesh. Incoming flits arrive on a valid/ready stream and are queued in a small FIFO. A counter tracks how many flits are queued, and that count is exported as the port's congestion level for use by a traffic controller.

For the flit at the head of the queue, the port chooses an output direction. It compares the router's own coordinates with the flit's destination. When both axes still need hops, it picks between the two minimal directions using the traffic levels reported for the neighbours. The flit's source coordinates can forbid that choice: a flit whose destination lies west of its source must finish its westward hops before it turns.

The port presents a switch request and a one-hot port request to the switch allocator. A grant from the allocator dequeues one flit. The direction chosen for a head flit is kept for every following flit until the tail flit has been granted.

Back-pressure follows two rules. On the input stream, a flit transfers only in a cycle where both `in_valid` and `in_ready` are high, and `in_ready` drops when the FIFO is full. `stop_out` is an early warning for the upstream router: it rises when one free slot or none is left. On the output side, `sw_req` acts as the valid signal and `sw_grant` as the ready signal. A flit leaves only when both are high.

Top module: `mesh_inport`

## Requirements
- R1: Flit fields are fixed: bit 0 marks a tail flit. Bits 5:1 carry the one-hot next port. Destination X is in bits 8:6 and destination Y in bits 11:9. Payload occupies bits 75:12. Source X is in bits 78:76 and source Y in bits 81:79.
- R2: `occupancy` rises by one on an accepted input flit and falls by one on a granted request. It stays unchanged when both happen in the same cycle.
- R3: `in_ready` is low while `occupancy` equals DEPTH, and a flit offered then is dropped. A grant with no request has no effect, so `occupancy` never goes above DEPTH or below zero.
- R4: `stop_out` is high exactly when `occupancy` is at least DEPTH-1.
- R5: `sw_req` is high exactly when the FIFO holds a flit. Then `port_req` has exactly one bit set; otherwise `port_req` is zero. The bit order is: bit 0 Local, bit 1 North (Y increasing), bit 2 South, bit 3 West (X decreasing), bit 4 East.
- R6: A flit whose destination equals (`my_x`,`my_y`) is sent to Local.
- R7: When only one axis differs, the single minimal direction on that axis is chosen, whatever the traffic.
- R8: When both axes differ and destination X is not below source X, the minimal direction whose neighbour traffic is strictly lower wins. A tie goes to the X direction. Neighbour traffic is read from `nbr_traffic[3*i+2:3*i]`, where i is the port's bit index from R5.
- R9: When both axes differ and destination X is below source X, West is chosen regardless of traffic.
- R10: The port chosen for a non-tail head flit is kept for the following flits until a tail flit is granted. The next flit after that is routed afresh.
- R11: Flits leave in arrival order. `out_flit` equals the stored flit, except that bits 5:1 are replaced by `port_req`.
- R12: After reset the FIFO is empty, `occupancy` is 0, `in_ready` is high and `stop_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 3 | X coordinate of this router |
| my_y | input | 3 | Y coordinate of this router |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | FIFO can accept a flit |
| in_flit | input | 82 | Input flit |
| stop_out | output | 1 | Early back-pressure to the upstream router |
| nbr_traffic | input | 15 | Traffic level per direction, 3 bits each |
| sw_req | output | 1 | Request to the switch allocator |
| port_req | output | 5 | One-hot requested output port |
| sw_grant | input | 1 | Grant for the head flit |
| out_flit | output | 82 | Head flit with the chosen next port inserted |
| occupancy | output | 3 | Number of queued flits |

## Verification
The bench builds the port with its defaults: DEPTH 4, 3-bit coordinates and 3-bit traffic levels. With a depth of four, both the early-stop threshold and the full condition are reached within a few pushes. The read and write pointers also wrap after every four packets, so the routing vectors exercise pointer wrap as a side effect. The 3-bit coordinates let the vectors place the router and its destinations at the corners and the middle of an 8-by-8 mesh.

// File: rtl/mip_pkg.sv
package mip_pkg;
  localparam int FLIT_W  = 82;
  localparam int NPORT   = 5;
  localparam int TAIL_B  = 0;
  localparam int NP_LO   = 1;
  localparam int DX_LO   = 6;
  localparam int DY_LO   = 9;
  localparam int SX_LO   = 76;
  localparam int SY_LO   = 79;
  localparam int FLD_W   = 3;

  // one-hot bit index of each output direction
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_WEST  = 3;
  localparam int P_EAST  = 4;

  typedef logic [NPORT-1:0] port_oh_t;
endpackage

// File: rtl/mip_occ_counter.sv
module mip_occ_counter #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case ({up, dn})
        2'b10:   if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/mip_fifo.sv
module mip_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 82
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/mip_route.sv
module mip_route
  import mip_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int TRAF_W  = 3
) (
  input  logic [COORD_W-1:0]      my_x,
  input  logic [COORD_W-1:0]      my_y,
  input  logic [COORD_W-1:0]      dst_x,
  input  logic [COORD_W-1:0]      dst_y,
  input  logic [COORD_W-1:0]      src_x,
  input  logic [NPORT*TRAF_W-1:0] traffic,
  output port_oh_t                port_oh
);
  logic [TRAF_W-1:0] lvl [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_lvl
    assign lvl[i] = traffic[i*TRAF_W +: TRAF_W];
  end

  logic              need_x, need_y, west_only;
  port_oh_t          x_oh, y_oh;
  logic [TRAF_W-1:0] x_lvl, y_lvl;

  always_comb begin
    need_x    = (dst_x != my_x);
    need_y    = (dst_y != my_y);
    west_only = (dst_x < src_x);
    x_oh      = '0;
    y_oh      = '0;
    if (dst_x > my_x) begin
      x_oh[P_EAST] = 1'b1;
      x_lvl        = lvl[P_EAST];
    end else begin
      x_oh[P_WEST] = 1'b1;
      x_lvl        = lvl[P_WEST];
    end
    if (dst_y > my_y) begin
      y_oh[P_NORTH] = 1'b1;
      y_lvl         = lvl[P_NORTH];
    end else begin
      y_oh[P_SOUTH] = 1'b1;
      y_lvl         = lvl[P_SOUTH];
    end

    port_oh = '0;
    if (!need_x && !need_y)  port_oh[P_LOCAL] = 1'b1;
    else if (!need_y)        port_oh = x_oh;
    else if (!need_x)        port_oh = y_oh;
    else if (west_only)      port_oh = x_oh;
    else if (y_lvl < x_lvl)  port_oh = y_oh;
    else                     port_oh = x_oh;
  end
endmodule

// File: rtl/mesh_inport.sv
module mesh_inport
  import mip_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int COORD_W = 3,
  parameter int TRAF_W  = 3,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [COORD_W-1:0]      my_x,
  input  logic [COORD_W-1:0]      my_y,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FLIT_W-1:0]       in_flit,
  output logic                    stop_out,
  input  logic [NPORT*TRAF_W-1:0] nbr_traffic,
  output logic                    sw_req,
  output logic [NPORT-1:0]        port_req,
  input  logic                    sw_grant,
  output logic [FLIT_W-1:0]       out_flit,
  output logic [CNT_W-1:0]        occupancy
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WARN_LVL = CNT_W'(DEPTH - 1);

  logic              enq, deq;
  logic [CNT_W-1:0]  occ;
  logic [FLIT_W-1:0] head;
  port_oh_t          route_now, route_q, port_sel;
  logic              route_lock;

  assign in_ready = (occ != FULL_LVL);
  assign stop_out = (occ >= WARN_LVL);
  assign sw_req   = (occ != '0);
  assign enq      = in_valid && in_ready;
  assign deq      = sw_req && sw_grant;

  mip_occ_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk (clk),
    .rst_n (rst_n),
    .up  (enq),
    .dn  (deq),
    .cnt (occ)
  );

  mip_fifo #(.DEPTH(DEPTH), .W(FLIT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (enq),
    .pop   (deq),
    .wdata (in_flit),
    .rdata (head)
  );

  mip_route #(.COORD_W(COORD_W), .TRAF_W(TRAF_W)) u_route (
    .my_x    (my_x),
    .my_y    (my_y),
    .dst_x   (head[DX_LO +: COORD_W]),
    .dst_y   (head[DY_LO +: COORD_W]),
    .src_x   (head[SX_LO +: COORD_W]),
    .traffic (nbr_traffic),
    .port_oh (route_now)
  );

  // packet route lock: set by a granted non-tail flit, cleared by the tail
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_lock <= 1'b0;
      route_q    <= '0;
    end else if (deq) begin
      route_lock <= !head[TAIL_B];
      route_q    <= port_sel;
    end
  end

  assign port_sel  = route_lock ? route_q : route_now;
  assign port_req  = sw_req ? port_sel : '0;
  assign out_flit  = {head[FLIT_W-1:NP_LO+NPORT], port_req, head[TAIL_B]};
  assign occupancy = occ;
endmodule

// File: rtl/mip_chk.sv
module mip_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             stop_out,
  input logic             sw_req,
  input logic [4:0]       port_req,
  input logic             sw_grant,
  input logic [81:0]      out_flit,
  input logic [CNT_W-1:0] occupancy
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(sw_req && sw_grant))
    |=> occupancy == CNT_W'($past(occupancy) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sw_req && sw_grant) |=> $stable(occupancy));

  a_r4_stop_level: assert property (@(posedge clk) disable iff (!rst_n)
    stop_out == (occupancy >= CNT_W'(DEPTH - 1)));

  a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> (!sw_req && port_req == '0));

  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> $countones(port_req) == 1);

  a_r10_route_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_grant && !out_flit[0])
    |=> (!sw_req || port_req == $past(port_req)));

  a_r11_port_field: assert property (@(posedge clk) disable iff (!rst_n)
    out_flit[5:1] == port_req);
endmodule

bind mesh_inport mip_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .stop_out  (stop_out),
  .sw_req    (sw_req),
  .port_req  (port_req),
  .sw_grant  (sw_grant),
  .out_flit  (out_flit),
  .occupancy (occupancy)
);

// File: tb/sim_mesh_inport.sv
module sim_mesh_inport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  my_x = '0, my_y = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [81:0] in_flit = '0;
  logic        stop_out;
  logic [14:0] nbr_traffic = '0;
  logic        sw_req;
  logic [4:0]  port_req;
  logic        sw_grant = 1'b0;
  logic [81:0] out_flit;
  logic [2:0]  occupancy;

  int n_run = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mesh_inport u0 (
    .clk (clk), .rst_n (rst_n), .my_x (my_x), .my_y (my_y),
    .in_valid (in_valid), .in_ready (in_ready), .in_flit (in_flit),
    .stop_out (stop_out), .nbr_traffic (nbr_traffic), .sw_req (sw_req),
    .port_req (port_req), .sw_grant (sw_grant), .out_flit (out_flit),
    .occupancy (occupancy)
  );

  // vector: {xc,yc,xd,yd,xs,ys, traffic {E,W,S,N,L}, expected port}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {3'd3,3'd3,3'd3,3'd3,3'd0,3'd0,{3'd0,3'd0,3'd0,3'd0,3'd0},5'b00001},
    {3'd3,3'd3,3'd5,3'd3,3'd0,3'd0,{3'd7,3'd0,3'd0,3'd0,3'd0},5'b10000},
    {3'd3,3'd3,3'd1,3'd3,3'd5,3'd5,{3'd0,3'd6,3'd0,3'd0,3'd0},5'b01000},
    {3'd3,3'd3,3'd3,3'd6,3'd0,3'd0,{3'd0,3'd0,3'd0,3'd7,3'd0},5'b00010},
    {3'd3,3'd3,3'd3,3'd0,3'd0,3'd0,{3'd0,3'd0,3'd5,3'd0,3'd0},5'b00100},
    {3'd3,3'd3,3'd5,3'd6,3'd0,3'd0,{3'd5,3'd0,3'd0,3'd2,3'd0},5'b00010},
    {3'd3,3'd3,3'd5,3'd6,3'd0,3'd0,{3'd1,3'd0,3'd0,3'd6,3'd0},5'b10000},
    {3'd3,3'd3,3'd5,3'd6,3'd0,3'd0,{3'd3,3'd0,3'd0,3'd3,3'd0},5'b10000},
    {3'd3,3'd3,3'd6,3'd1,3'd1,3'd7,{3'd4,3'd0,3'd1,3'd0,3'd0},5'b00100},
    {3'd3,3'd3,3'd1,3'd6,3'd6,3'd0,{3'd0,3'd7,3'd0,3'd0,3'd0},5'b01000},
    {3'd3,3'd3,3'd1,3'd6,3'd1,3'd0,{3'd0,3'd5,3'd0,3'd2,3'd0},5'b00010},
    {3'd0,3'd7,3'd0,3'd7,3'd4,3'd4,{3'd1,3'd1,3'd1,3'd1,3'd1},5'b00001},
    {3'd3,3'd3,3'd0,3'd0,3'd7,3'd7,{3'd0,3'd6,3'd0,3'd0,3'd0},5'b01000}
  };

  task automatic check(input string tag, input logic [81:0] act, input logic [81:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [81:0] mk(input logic [2:0] xd, input logic [2:0] yd,
                                     input logic [2:0] xs, input logic [2:0] ys,
                                     input logic tail, input logic [63:0] pay);
    logic [81:0] f;
    f = '0;
    f[0] = tail;
    f[8:6] = xd;
    f[11:9] = yd;
    f[75:12] = pay;
    f[78:76] = xs;
    f[81:79] = ys;
    return f;
  endfunction

  task automatic push(input logic [81:0] f);
    @(negedge clk);
    in_flit = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic grant();
    @(negedge clk);
    sw_grant = 1'b1;
    @(negedge clk);
    sw_grant = 1'b0;
  endtask

  logic done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [81:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 occupancy", 82'(occupancy), 82'd0);
    check("R12 in_ready", 82'(in_ready), 82'd1);
    check("R12 stop_out", 82'(stop_out), 82'd0);
    check("R5 idle request", 82'({sw_req, port_req}), 82'd0);

    // routing table: R1 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      my_x = v[37:35];
      my_y = v[34:32];
      nbr_traffic = v[19:5];
      f = mk(v[31:29], v[28:26], v[25:23], v[22:20], 1'b1, 64'hA5A5_0000_0000_0000 + 64'(i));
      push(f);
      check($sformatf("R6 R7 R8 R9 route vec %0d", i), 82'(port_req), 82'(v[4:0]));
      check($sformatf("R11 flit body vec %0d", i), {out_flit[81:6], 6'd0}, {f[81:6], 6'd0});
      check($sformatf("R1 port field vec %0d", i), 82'(out_flit[5:1]), 82'(v[4:0]));
      grant();
      check($sformatf("R2 drained vec %0d", i), 82'(occupancy), 82'd0);
    end

    // fill to full: R2 R3 R4
    my_x = 3'd3; my_y = 3'd3; nbr_traffic = '0;
    for (int k = 0; k < 4; k++) begin
      push(mk(3'd5, 3'd3, 3'd0, 3'd0, 1'b1, 64'(100 + k)));
      check("R2 count rises", 82'(occupancy), 82'(k + 1));
      check("R4 stop level", 82'(stop_out), 82'(k + 1 >= 3));
    end
    check("R3 ready low when full", 82'(in_ready), 82'd0);
    push(mk(3'd5, 3'd3, 3'd0, 3'd0, 1'b1, 64'd999));
    check("R3 dropped when full", 82'(occupancy), 82'd4);
    for (int k = 0; k < 4; k++) begin
      check("R11 order", 82'(out_flit[75:12]), 82'(100 + k));
      grant();
    end
    check("R3 empty after drain", 82'({occupancy, sw_req}), 82'd0);

    // grant while empty: R3
    grant();
    check("R3 no underflow", 82'(occupancy), 82'd0);
    push(mk(3'd3, 3'd3, 3'd0, 3'd0, 1'b1, 64'd7));
    check("R3 count after idle grant", 82'(occupancy), 82'd1);

    // simultaneous push and grant: R2
    @(negedge clk);
    in_flit = mk(3'd3, 3'd3, 3'd0, 3'd0, 1'b1, 64'd8);
    in_valid = 1'b1;
    sw_grant = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    sw_grant = 1'b0;
    check("R2 push and grant hold count", 82'(occupancy), 82'd1);
    check("R11 new head after swap", 82'(out_flit[75:12]), 82'd8);
    grant();

    // packet route hold: R10
    nbr_traffic = {3'd1, 3'd0, 3'd0, 3'd6, 3'd0};
    push(mk(3'd5, 3'd6, 3'd0, 3'd0, 1'b0, 64'd20));
    push(mk(3'd3, 3'd3, 3'd0, 3'd0, 1'b0, 64'd21));
    push(mk(3'd3, 3'd0, 3'd0, 3'd0, 1'b1, 64'd22));
    check("R10 head route", 82'(port_req), 82'b10000);
    grant();
    nbr_traffic = {3'd7, 3'd0, 3'd0, 3'd0, 3'd0};
    @(negedge clk);
    check("R10 body keeps route", 82'(port_req), 82'b10000);
    grant();
    check("R10 tail keeps route", 82'(port_req), 82'b10000);
    grant();
    push(mk(3'd5, 3'd6, 3'd0, 3'd0, 1'b1, 64'd23));
    check("R10 next packet rerouted", 82'(port_req), 82'b00010);
    grant();
    check("R5 idle after all", 82'({sw_req, port_req}), 82'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule